// File: doc/BRIEF.md
# Transmit Link Bring-Up Sequencer

This block brings one node's serial transmitter from reset to a usable link. After reset it waits for the serializer's shared PLL to lock. It then waits for the transceiver to report that its internal reset has finished. It also waits for the auxiliary clock locks. These are the lock of the divide-by-two PLL and, on a slave node only, the lock of the clock-recovery digital PLL.

Once every lock is present, the block runs a transmit phase-alignment handshake. This handshake ties the fabric word clock to the serializer's parallel clock. Without it, the latency from fabric to serial line can take either of two values 8 ns apart.

When alignment completes, the transmitter sends only IDLE code-groups. A master node then allows data straight away. A slave node keeps sending IDLE until it receives a data packet from the master, which marks the end of the reset sequence. If any lock is lost once the lock checks have started, the block falls back to the start of the sequence and forces IDLE.

States, with their `seq_state` code:

| State | Code | Meaning |
|---|---|---|
| WAIT_PLL | 0 | Waiting for the shared PLL lock. |
| WAIT_RDONE | 1 | Waiting for transceiver reset-done. |
| WAIT_AUX | 2 | Waiting for the divide-by-two lock and, on a slave, the DPLL lock. |
| ALIGN_EN | 3 | Alignment enable is held. |
| ALIGN_RST | 4 | Alignment enable and alignment reset are both held. |
| ALIGN_SETTLE | 5 | Alignment enable is held while the alignment settles. |
| LINK_IDLE | 6 | Aligned; IDLE only. |
| DATA | 7 | Data packets allowed. |

Transitions:

| From | To | Condition |
|---|---|---|
| WAIT_PLL | WAIT_RDONE | On PLL lock. |
| WAIT_RDONE | WAIT_AUX | On reset-done. |
| WAIT_RDONE | WAIT_PLL | On loss of PLL lock. |
| WAIT_AUX | ALIGN_EN | When the auxiliary locks are present. |
| WAIT_AUX | WAIT_PLL | On loss of PLL lock or of reset-done. |
| ALIGN_EN | ALIGN_RST | After `EN_CYC` cycles. |
| ALIGN_RST | ALIGN_SETTLE | After `RST_CYC` cycles. |
| ALIGN_SETTLE | LINK_IDLE | After `SETTLE_CYC` cycles. |
| LINK_IDLE | DATA | Immediately on a master; on a received master packet on a slave. |
| ALIGN_EN to DATA | WAIT_PLL | On loss of any required lock. |

Top module: `tx_bringup_seq`

## Requirements
- R1: While reset is asserted, and right after it, `seq_state` is 0 (WAIT_PLL). In that state `phalign_en`, `phalign_rst`, `tx_active`, `tx_data_ok` and `link_ready` are all 0.
- R2: Reset-done is only acted on after PLL lock. With PLL lock low, the block stays in state 0 whatever the other inputs are. With PLL lock high and reset-done low, it stays in state 1. Losing PLL lock in state 1 returns the block to state 0 on the next clock.
- R3: With PLL lock and reset-done both high but the divide-by-two lock low, the block stays in state 2 and never raises `phalign_en`.
- R4: When `IS_SLAVE`=1, the DPLL lock is also required to leave state 2. When `IS_SLAVE`=0, the DPLL lock input has no effect at any point.
- R5: Once all locks are present, the block moves through states 0, 1 and 2 on three successive clocks. It then holds `phalign_en` high for exactly `EN_CYC`+`RST_CYC`+`SETTLE_CYC` cycles. Within that window, `phalign_rst` is high for exactly `RST_CYC` cycles, starting after the first `EN_CYC` cycles. `phalign_rst` is never high while `phalign_en` is low.
- R6: `link_ready` and `tx_active` rise together, `EN_CYC`+`RST_CYC`+`SETTLE_CYC`+3 clocks after reset is released with all locks present. In state 6, `tx_data_ok` is 0, so only IDLE is sent.
- R7: A master (`IS_SLAVE`=0) enters state 7 with `tx_data_ok`=1 one clock after state 6. A slave enters state 7 on the clock that samples `rx_data_pkt` high while it is in state 6.
- R8: On a slave, an `rx_data_pkt` pulse that arrives before state 6 has no effect. The slave still stays in state 6 with `tx_data_ok`=0 until a later packet arrives.
- R9: In states 3 to 7, losing any required lock returns the block to state 0 on the next clock. The required locks are PLL lock, reset-done, divide-by-two lock and, on a slave, DPLL lock. In state 0, `link_ready`, `tx_active`, `tx_data_ok` and `phalign_en` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit word clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_pll_lock | input | 1 | Shared serializer PLL is locked |
| xcvr_rst_done | input | 1 | Transceiver internal reset finished |
| half_pll_lock | input | 1 | Divide-by-two PLL is locked |
| dpll_lock | input | 1 | Clock-recovery digital PLL is locked (slave only) |
| rx_data_pkt | input | 1 | One-cycle pulse: data packet received from the master |
| phalign_en | output | 1 | Phase-alignment enable |
| phalign_rst | output | 1 | Phase-alignment reset |
| tx_active | output | 1 | Transmitter is sending (IDLE or data) |
| tx_data_ok | output | 1 | Data packets may be sent |
| link_ready | output | 1 | Alignment is complete and the link is usable |
| seq_state | output | 3 | Current state code (0 to 7, as listed above) |

## Verification
All sixteen combinations of the four lock inputs are applied from reset, to a slave and to a master at the same time. The state each one settles in is compared with the state that the lock ordering predicts, which separates the PLL, reset-done and auxiliary gates. It also shows the master ignoring the DPLL lock.

A full bring-up is traced one cycle at a time, with short alignment timings and with the default timings. This pins down the exact lengths of the enable and reset windows and the cycle on which the link becomes ready.

Packets delivered too early and packets delivered in state 6 show the difference between an ignored packet and an accepted one. Each lock is then dropped in turn, from state 7 and from the middle of alignment, to exercise the fallback path.

// File: rtl/tx_bringup_pkg.sv
package tx_bringup_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        ST_WAIT_PLL     = 3'd0,
        ST_WAIT_RDONE   = 3'd1,
        ST_WAIT_AUX     = 3'd2,
        ST_ALIGN_EN     = 3'd3,
        ST_ALIGN_RST    = 3'd4,
        ST_ALIGN_SETTLE = 3'd5,
        ST_LINK_IDLE    = 3'd6,
        ST_DATA         = 3'd7
    } bup_state_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        return m;
    endfunction

endpackage

// File: rtl/bup_lock_qual.sv
module bup_lock_qual #(
    parameter bit IS_SLAVE = 1'b1
) (
    input  logic ser_pll_lock,
    input  logic xcvr_rst_done,
    input  logic half_pll_lock,
    input  logic dpll_lock,
    output logic base_ok,
    output logic aux_ok,
    output logic all_ok
);

    assign base_ok = ser_pll_lock & xcvr_rst_done;

    generate
        if (IS_SLAVE) begin : g_slave
            assign aux_ok = half_pll_lock & dpll_lock;
        end else begin : g_master
            logic unused_dpll;
            assign unused_dpll = dpll_lock;
            assign aux_ok = half_pll_lock;
        end
    endgenerate

    assign all_ok = base_ok & aux_ok;

endmodule

// File: rtl/bup_phase_timer.sv
module bup_phase_timer #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            count <= '0;
        end else if (count != {CNT_W{1'b1}}) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/tx_bringup_seq.sv
module tx_bringup_seq
    import tx_bringup_pkg::*;
#(
    parameter bit IS_SLAVE   = 1'b1,
    parameter int EN_CYC     = 32,
    parameter int RST_CYC    = 16,
    parameter int SETTLE_CYC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ser_pll_lock,
    input  logic               xcvr_rst_done,
    input  logic               half_pll_lock,
    input  logic               dpll_lock,
    input  logic               rx_data_pkt,
    output logic               phalign_en,
    output logic               phalign_rst,
    output logic               tx_active,
    output logic               tx_data_ok,
    output logic               link_ready,
    output logic [STATE_W-1:0] seq_state
);

    localparam int MAX_CYC = max3(EN_CYC, RST_CYC, SETTLE_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] EN_LAST     = CNT_W'(EN_CYC - 1);
    localparam logic [CNT_W-1:0] RST_LAST    = CNT_W'(RST_CYC - 1);
    localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYC - 1);

    bup_state_e       state_q, state_d;
    logic             base_ok, aux_ok, all_ok;
    logic [CNT_W-1:0] tmr_cnt;
    logic             tmr_restart;

    bup_lock_qual #(.IS_SLAVE(IS_SLAVE)) u_locks (
        .ser_pll_lock (ser_pll_lock),
        .xcvr_rst_done(xcvr_rst_done),
        .half_pll_lock(half_pll_lock),
        .dpll_lock    (dpll_lock),
        .base_ok      (base_ok),
        .aux_ok       (aux_ok),
        .all_ok       (all_ok)
    );

    assign tmr_restart = (state_d != state_q);

    bup_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tmr_restart),
        .count  (tmr_cnt)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_PLL: begin
                if (ser_pll_lock) state_d = ST_WAIT_RDONE;
            end
            ST_WAIT_RDONE: begin
                if (!ser_pll_lock)      state_d = ST_WAIT_PLL;
                else if (xcvr_rst_done) state_d = ST_WAIT_AUX;
            end
            ST_WAIT_AUX: begin
                if (!base_ok)    state_d = ST_WAIT_PLL;
                else if (aux_ok) state_d = ST_ALIGN_EN;
            end
            ST_ALIGN_EN: begin
                if (!all_ok)                 state_d = ST_WAIT_PLL;
                else if (tmr_cnt == EN_LAST) state_d = ST_ALIGN_RST;
            end
            ST_ALIGN_RST: begin
                if (!all_ok)                  state_d = ST_WAIT_PLL;
                else if (tmr_cnt == RST_LAST) state_d = ST_ALIGN_SETTLE;
            end
            ST_ALIGN_SETTLE: begin
                if (!all_ok)                     state_d = ST_WAIT_PLL;
                else if (tmr_cnt == SETTLE_LAST) state_d = ST_LINK_IDLE;
            end
            ST_LINK_IDLE: begin
                if (!all_ok)                          state_d = ST_WAIT_PLL;
                else if (!IS_SLAVE || rx_data_pkt)    state_d = ST_DATA;
            end
            ST_DATA: begin
                if (!all_ok) state_d = ST_WAIT_PLL;
            end
            default: state_d = ST_WAIT_PLL;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_PLL;
        else        state_q <= state_d;
    end

    // Output decode
    always_comb begin
        phalign_en  = 1'b0;
        phalign_rst = 1'b0;
        tx_active   = 1'b0;
        tx_data_ok  = 1'b0;
        link_ready  = 1'b0;
        unique case (state_q)
            ST_WAIT_PLL, ST_WAIT_RDONE, ST_WAIT_AUX: ;
            ST_ALIGN_EN, ST_ALIGN_SETTLE: phalign_en = 1'b1;
            ST_ALIGN_RST: begin
                phalign_en  = 1'b1;
                phalign_rst = 1'b1;
            end
            ST_LINK_IDLE: begin
                tx_active  = 1'b1;
                link_ready = 1'b1;
            end
            ST_DATA: begin
                tx_active  = 1'b1;
                link_ready = 1'b1;
                tx_data_ok = 1'b1;
            end
            default: ;
        endcase
    end

    assign seq_state = state_q;

    // R2: reset-done is honoured only after PLL lock
    p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_AUX && $past(state_q) == ST_WAIT_RDONE)
            |-> $past(ser_pll_lock && xcvr_rst_done));

    // R3: alignment never starts without the divide-by-two lock
    p_half_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ALIGN_EN && $past(state_q) == ST_WAIT_AUX)
            |-> $past(half_pll_lock));

    // R5: alignment reset only ever inside the enable window, and entered from enable
    p_rst_in_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phalign_rst) |-> $past(phalign_en));

    // R9: a lost lock sends the sequence back to the start
    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q inside {ST_ALIGN_EN, ST_ALIGN_RST, ST_ALIGN_SETTLE,
                         ST_LINK_IDLE, ST_DATA} && !all_ok)
            |=> (state_q == ST_WAIT_PLL));

    generate
        if (IS_SLAVE) begin : g_slave_chk
            // R4: slave alignment also requires the DPLL lock
            p_dpll_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (state_q == ST_ALIGN_EN && $past(state_q) == ST_WAIT_AUX)
                    |-> $past(dpll_lock));
            // R7/R8: slave data enable follows a packet seen in state 6
            p_data_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(tx_data_ok)
                    |-> ($past(rx_data_pkt) && $past(state_q) == ST_LINK_IDLE));
        end
    endgenerate

endmodule

// File: tb/tb_tx_bringup_seq.sv
module tb_tx_bringup_seq;

    localparam int CLK_PERIOD = 10;
    localparam int E = 4;
    localparam int R = 3;
    localparam int S = 5;
    localparam int DE = 32;
    localparam int DR = 16;
    localparam int DS = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pll = 1'b0, rdone = 1'b0, half = 1'b0, dpll = 1'b0, pkt = 1'b0;

    logic       s_en, s_rst, s_act, s_dok, s_rdy;
    logic [2:0] s_st;
    logic       m_en, m_rst, m_act, m_dok, m_rdy;
    logic [2:0] m_st;
    logic       d_en, d_rst, d_act, d_dok, d_rdy;
    logic [2:0] d_st;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tx_bringup_seq #(.IS_SLAVE(1'b1), .EN_CYC(E), .RST_CYC(R), .SETTLE_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .ser_pll_lock(pll), .xcvr_rst_done(rdone),
        .half_pll_lock(half), .dpll_lock(dpll), .rx_data_pkt(pkt),
        .phalign_en(s_en), .phalign_rst(s_rst), .tx_active(s_act),
        .tx_data_ok(s_dok), .link_ready(s_rdy), .seq_state(s_st));

    tx_bringup_seq #(.IS_SLAVE(1'b0), .EN_CYC(E), .RST_CYC(R), .SETTLE_CYC(S)) dut_m (
        .clk(clk), .rst_n(rst_n), .ser_pll_lock(pll), .xcvr_rst_done(rdone),
        .half_pll_lock(half), .dpll_lock(dpll), .rx_data_pkt(pkt),
        .phalign_en(m_en), .phalign_rst(m_rst), .tx_active(m_act),
        .tx_data_ok(m_dok), .link_ready(m_rdy), .seq_state(m_st));

    tx_bringup_seq dut_d (
        .clk(clk), .rst_n(rst_n), .ser_pll_lock(pll), .xcvr_rst_done(rdone),
        .half_pll_lock(half), .dpll_lock(dpll), .rx_data_pkt(pkt),
        .phalign_en(d_en), .phalign_rst(d_rst), .tx_active(d_act),
        .tx_data_ok(d_dok), .link_ready(d_rdy), .seq_state(d_st));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic p, input logic rd, input logic h, input logic d);
        @(negedge clk);
        rst_n = 1'b0;
        pkt = 1'b0;
        pll = p; rdone = rd; half = h; dpll = d;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bring_up();
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        step(3 + E + R + S + 1);
        pkt = 1'b1;
        @(negedge clk);
        pkt = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 state", int'(s_st), 0);
        chk("R1 outputs", int'({s_en, s_rst, s_act, s_dok, s_rdy}), 0);
        rst_n = 1'b1;

        // R2/R3/R4: sweep of all lock combinations
        for (int c = 0; c < 16; c++) begin
            logic p, rd, h, d;
            int exp_s, exp_m;
            p = c[0]; rd = c[1]; h = c[2]; d = c[3];
            do_reset(p, rd, h, d);
            step(3);
            exp_s = !p ? 0 : !rd ? 1 : !(h && d) ? 2 : 3;
            exp_m = !p ? 0 : !rd ? 1 : !h ? 2 : 3;
            chk($sformatf("R2 R3 R4 slave combo %0d", c), int'(s_st), exp_s);
            chk($sformatf("R2 R3 R4 master combo %0d", c), int'(m_st), exp_m);
            if (!h) chk("R3 no enable", int'(s_en | m_en), 0);
        end

        // R2: PLL loss while waiting for reset-done
        do_reset(1'b1, 1'b0, 1'b1, 1'b1);
        step(3);
        chk("R2 in state 1", int'(s_st), 1);
        pll = 1'b0;
        @(negedge clk);
        chk("R2 back to 0", int'(s_st), 0);

        // R5/R6/R7: traced full bring-up
        begin
            int en_n = 0, rst_cnt = 0, en_before = 0, rdy_at = 0, mdat_at = 0, drdy_at = 0;
            int bad_rst = 0;
            do_reset(1'b1, 1'b1, 1'b1, 1'b1);
            for (int i = 1; i <= 3 + DE + DR + DS + 3; i++) begin
                @(negedge clk);
                if (s_en) en_n++;
                if (s_rst) rst_cnt++;
                if (s_en && !s_rst && rst_cnt == 0) en_before++;
                if (s_rst && !s_en) bad_rst++;
                if (s_rdy && rdy_at == 0) rdy_at = i;
                if (m_dok && mdat_at == 0) mdat_at = i;
                if (d_rdy && drdy_at == 0) drdy_at = i;
                if (i == 3 + E + R + S + 2) begin
                    chk("R6 slave idle only", int'(s_dok), 0);
                    chk("R6 slave tx active", int'(s_act), 1);
                    chk("R6 slave state 6", int'(s_st), 6);
                end
            end
            chk("R5 enable length", en_n, E + R + S);
            chk("R5 reset length", rst_cnt, R);
            chk("R5 reset offset", en_before, E);
            chk("R5 reset without enable", bad_rst, 0);
            chk("R6 ready cycle", rdy_at, 3 + E + R + S);
            chk("R7 master data cycle", mdat_at, 3 + E + R + S + 1);
            chk("R6 default-timing ready cycle", drdy_at, 3 + DE + DR + DS);
        end

        // R8: early packets ignored; R7: later packet accepted
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        pkt = 1'b1; @(negedge clk); pkt = 1'b0;
        step(3);
        pkt = 1'b1; @(negedge clk); pkt = 1'b0;
        step(E + R + S + 4);
        chk("R8 still state 6", int'(s_st), 6);
        chk("R8 no data", int'(s_dok), 0);
        pkt = 1'b1; @(negedge clk); pkt = 1'b0;
        chk("R7 slave state 7", int'(s_st), 7);
        chk("R7 slave data ok", int'(s_dok), 1);

        // R9: drop each lock from state 7
        for (int b = 0; b < 4; b++) begin
            bring_up();
            chk("R7 slave up", int'(s_st), 7);
            case (b)
                0: pll = 1'b0;
                1: rdone = 1'b0;
                2: half = 1'b0;
                default: dpll = 1'b0;
            endcase
            @(negedge clk);
            chk($sformatf("R9 slave drop %0d", b), int'(s_st), 0);
            chk($sformatf("R9 slave outputs %0d", b),
                int'({s_en, s_act, s_dok, s_rdy}), 0);
            chk($sformatf("R4 R9 master drop %0d", b), int'(m_st), (b == 3) ? 7 : 0);
        end

        // R9: drop during alignment reset
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        step(3 + E + 1);
        chk("R5 in align reset", int'(s_st), 4);
        half = 1'b0;
        @(negedge clk);
        chk("R9 align drop", int'(s_st), 0);
        chk("R9 align enable off", int'(s_en), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule